// File: doc/BRIEF.md
# Locked Scan Segment Gate with Trap Cells

This block sits in a reconfigurable test-access scan network. It guards a hidden instrument's scan segment. A single segment-select cell decides whether that segment is spliced into the scan path. With the cell closed, the segment is skipped. With the cell open, the segment's scan-in and scan-out pair sits between this cell and `scan_out`. The select cell will only accept a 1 when a row of key cells elsewhere in the chain carries a fixed secret value in the same update. Trap cells set a sticky lock that no scan sequence can clear once one of them is updated with anything other than its expected value. A freely openable decoy segment looks like progress to an attacker but controls nothing.

All cells follow one scheme. Each has a shift flop clocked on the rising test clock, where capture loads the cell's own update value. Each also has an update flop written on the falling edge while `upd_en` is high. The global reset is asynchronous and active low. The instrument behind the hidden segment is outside this block. It sees `seg_sel` and its scan input `seg_si`, and it drives `seg_so`.

The path, from `scan_in` to `scan_out`, runs in this order:
1. key cells 0..KEY_W-1
2. trap cells 0..N_TRAP-1
3. the decoy select cell
4. the decoy register cells 0..DECOY_W-1, present only while the decoy is open
5. the lock select cell
6. the hidden segment, present only while the lock cell is open

Top module: `lsib_net`

## Requirements
- R1: While `glob_rst_n` is low and just after it rises, both select cells are closed, `seg_sel` is 0, all trap update values equal their expected values, and the path is KEY_W+N_TRAP+2 bits long.
- R2: While the lock cell is closed, `scan_out` is the lock cell's shift bit. While it is open, `seg_si` carries that bit, `scan_out` follows `seg_so`, and the path grows by the segment length.
- R3: An update that writes 1 to the lock cell opens it only if all of the following hold at that update: the key cells' shift values equal KEY_VAL, with key cell k holding bit k; every trap shift value equals TRAP_EXP; and no lock is set. In every other case the update leaves the cell closed. The bench uses KEY_VAL=8'hA5.
- R4: An update that loads any trap cell with a value different from its expected bit sets the lock. The bench uses expected bits of 0. The lock cell is forced closed on that same update and cannot open while the lock is set.
- R5: The lock stays set through any scan sequence. Only `glob_rst_n` low clears it, after which the correct key opens the lock cell again.
- R6: The decoy select cell opens and closes on any written value without a key. While it is open, its DECOY_W register cells shift, update and read back data. Neither the decoy cell nor its register ever affects `seg_sel`.
- R7: A capture cycle loads every cell in the path with its current update value, so a following shift returns the select, trap, key and decoy states.
- R8: A closed or locked lock cell still contributes exactly one bit, so the path length is the same whether a key attempt failed, a trap fired, or no attempt was made.
- R9: An update that writes 0 to an open lock cell closes it whatever the key cells hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock: shift and capture on the rising edge, update on the falling edge |
| glob_rst_n | input | 1 | Asynchronous active-low global reset; the only way to clear the lock |
| cap_en | input | 1 | Capture enable: shift flops load their update values |
| shf_en | input | 1 | Shift enable: the path moves one bit toward `scan_out` |
| upd_en | input | 1 | Update enable: update flops load on the falling edge |
| scan_in | input | 1 | Serial data into the first key cell |
| scan_out | output | 1 | Serial data out of the lock cell or of the hidden segment |
| seg_sel | output | 1 | High while the hidden segment is spliced into the path |
| seg_si | output | 1 | Scan input to the hidden segment |
| seg_so | input | 1 | Scan output from the hidden segment |

## Verification
Update results are written on the falling edge of the update cycle. These are `seg_sel`, the lock and the path shape, and the bench samples them one cycle later in an idle cycle. A capture takes effect on the rising edge that closes the capture cycle. The bench therefore reads the bit on `scan_out` in each shift cycle one time unit before that cycle's rising edge, so bit i of a readback is the value of the i-th cell counted back from `scan_out`. Path length is measured by flushing zeros and then pushing a single 1. The count of shift cycles until the 1 shows on `scan_out` equals the length, and the bench compares it with the length its model expects.

// File: rtl/lsib_pkg.sv
`timescale 1ns/1ps
package lsib_pkg;
  // Scan control bundle shared by every cell in the network.
  typedef struct packed {
    logic cap;
    logic shf;
    logic upd;
  } scan_ctl_t;
endpackage

// File: rtl/lsib_cell.sv
`timescale 1ns/1ps
// One scan cell: rising-edge shift flop, falling-edge update flop.
module lsib_cell
  import lsib_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic      tck,
  input  logic      rst_n,
  input  scan_ctl_t ctl,
  input  logic      si,
  input  logic      upd_d,
  output logic      sh_q,
  output logic      up_q
);
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)       sh_q <= RST_VAL;
    else if (ctl.cap) sh_q <= up_q;
    else if (ctl.shf) sh_q <= si;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)       up_q <= RST_VAL;
    else if (ctl.upd) up_q <= upd_d;
  end
endmodule

// File: rtl/lsib_guard.sv
`timescale 1ns/1ps
// Key comparison and sticky trap lock for the locked select cell.
module lsib_guard #(
  parameter int                 KEY_W    = 8,
  parameter logic [KEY_W-1:0]   KEY_VAL  = 'hA5,
  parameter int                 N_TRAP   = 2,
  parameter logic [N_TRAP-1:0]  TRAP_EXP = '0
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [KEY_W-1:0]  key_sh,
  input  logic [N_TRAP-1:0] trap_sh,
  output logic              open_ok,
  output logic              locked
);
  logic key_hit;
  logic trap_ok;

  // Shift values are what the update flops take on this very edge.
  assign key_hit = (key_sh == KEY_VAL);
  assign trap_ok = (trap_sh == TRAP_EXP);
  assign open_ok = key_hit && trap_ok && !locked;

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)                locked <= 1'b0;
    else if (upd && !trap_ok)  locked <= 1'b1;
  end
endmodule

// File: rtl/lsib_decoy.sv
`timescale 1ns/1ps
// Decoy: a plain select cell fronting a register that controls nothing.
module lsib_decoy
  import lsib_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      tck,
  input  logic      rst_n,
  input  scan_ctl_t ctl,
  input  logic      si,
  output logic      so
);
  logic             sel_sh;
  logic             sel_up;
  scan_ctl_t        inner_ctl;
  logic [DEPTH:0]   dchain;
  logic [DEPTH-1:0] dup;

  lsib_cell u_sel (
    .tck(tck), .rst_n(rst_n), .ctl(ctl), .si(si),
    .upd_d(sel_sh), .sh_q(sel_sh), .up_q(sel_up)
  );

  // Inner cells act only while they sit in the path.
  assign inner_ctl = {ctl.cap & sel_up, ctl.shf & sel_up, ctl.upd & sel_up};
  assign dchain[0] = sel_sh;

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    lsib_cell u_bit (
      .tck(tck), .rst_n(rst_n), .ctl(inner_ctl), .si(dchain[g]),
      .upd_d(dchain[g+1]), .sh_q(dchain[g+1]), .up_q(dup[g])
    );
  end

  // The update values are held only so a capture can return them.
  logic unused_dup;
  assign unused_dup = ^dup;

  assign so = sel_up ? dchain[DEPTH] : sel_sh;
endmodule

// File: rtl/lsib_net.sv
`timescale 1ns/1ps
// Locked segment gate: key cells, trap cells, decoy, locked select cell.
module lsib_net
  import lsib_pkg::*;
#(
  parameter int                KEY_W    = 8,
  parameter logic [KEY_W-1:0]  KEY_VAL  = 'hA5,
  parameter int                N_TRAP   = 2,
  parameter logic [N_TRAP-1:0] TRAP_EXP = '0,
  parameter int                DECOY_W  = 4
) (
  input  logic tck,
  input  logic glob_rst_n,
  input  logic cap_en,
  input  logic shf_en,
  input  logic upd_en,
  input  logic scan_in,
  output logic scan_out,
  output logic seg_sel,
  output logic seg_si,
  input  logic seg_so
);
  scan_ctl_t          ctl;
  logic [KEY_W:0]     kchain;
  logic [N_TRAP:0]    tchain;
  logic [KEY_W-1:0]   key_sh;
  logic [KEY_W-1:0]   key_uq;
  logic [N_TRAP-1:0]  trap_sh;
  logic [N_TRAP-1:0]  trap_uq;
  logic               decoy_so;
  logic               open_ok;
  logic               locked;
  logic               lsib_sh;
  logic               lsib_up;

  assign ctl = {cap_en, shf_en, upd_en};

  // Key cells: key cell k holds key bit k, cell 0 nearest scan_in.
  assign kchain[0] = scan_in;
  for (genvar g = 0; g < KEY_W; g++) begin : g_key
    lsib_cell u_key (
      .tck(tck), .rst_n(glob_rst_n), .ctl(ctl), .si(kchain[g]),
      .upd_d(kchain[g+1]), .sh_q(kchain[g+1]), .up_q(key_uq[g])
    );
  end
  assign key_sh = kchain[KEY_W:1];

  // Trap cells reset to their expected value, i.e. disarmed.
  assign tchain[0] = kchain[KEY_W];
  for (genvar g = 0; g < N_TRAP; g++) begin : g_trap
    lsib_cell #(.RST_VAL(TRAP_EXP[g])) u_trap (
      .tck(tck), .rst_n(glob_rst_n), .ctl(ctl), .si(tchain[g]),
      .upd_d(tchain[g+1]), .sh_q(tchain[g+1]), .up_q(trap_uq[g])
    );
  end
  assign trap_sh = tchain[N_TRAP:1];

  lsib_decoy #(.DEPTH(DECOY_W)) u_decoy (
    .tck(tck), .rst_n(glob_rst_n), .ctl(ctl),
    .si(tchain[N_TRAP]), .so(decoy_so)
  );

  lsib_guard #(
    .KEY_W(KEY_W), .KEY_VAL(KEY_VAL), .N_TRAP(N_TRAP), .TRAP_EXP(TRAP_EXP)
  ) u_guard (
    .tck(tck), .rst_n(glob_rst_n), .upd(upd_en),
    .key_sh(key_sh), .trap_sh(trap_sh),
    .open_ok(open_ok), .locked(locked)
  );

  // Locked select cell: a 1 is only kept when the guard allows it.
  lsib_cell u_lsib (
    .tck(tck), .rst_n(glob_rst_n), .ctl(ctl), .si(decoy_so),
    .upd_d(lsib_sh & open_ok), .sh_q(lsib_sh), .up_q(lsib_up)
  );

  assign seg_sel  = lsib_up;
  assign seg_si   = lsib_sh;
  assign scan_out = lsib_up ? seg_so : lsib_sh;
endmodule

// File: rtl/lsib_net_chk.sv
`timescale 1ns/1ps
module lsib_net_chk #(
  parameter int                KEY_W    = 8,
  parameter logic [KEY_W-1:0]  KEY_VAL  = 'hA5,
  parameter int                N_TRAP   = 2,
  parameter logic [N_TRAP-1:0] TRAP_EXP = '0
) (
  input logic              tck,
  input logic              rst_n,
  input logic              seg_sel,
  input logic              seg_si,
  input logic              seg_so,
  input logic              scan_out,
  input logic              lsib_sh,
  input logic              locked,
  input logic [KEY_W-1:0]  key_uq,
  input logic [N_TRAP-1:0] trap_uq
);
  always @(posedge tck) begin
    if (!rst_n) begin
      p_reset_closed_r1: assert (!seg_sel && !locked && trap_uq == TRAP_EXP);
    end
  end

  p_bypass_r2: assert property (@(posedge tck) disable iff (!rst_n)
    !seg_sel |-> scan_out == lsib_sh);

  p_splice_r2: assert property (@(posedge tck) disable iff (!rst_n)
    seg_sel |-> (scan_out == seg_so && seg_si == lsib_sh));

  p_open_needs_key_r3: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(seg_sel) |-> (key_uq == KEY_VAL && trap_uq == TRAP_EXP && !locked));

  p_trap_locks_r4: assert property (@(posedge tck) disable iff (!rst_n)
    trap_uq != TRAP_EXP |-> locked);

  p_locked_closed_r4: assert property (@(posedge tck) disable iff (!rst_n)
    locked |-> !seg_sel);

  p_lock_sticky_r5: assert property (@(posedge tck) disable iff (!rst_n)
    locked |=> locked);
endmodule

bind lsib_net lsib_net_chk #(
  .KEY_W(KEY_W), .KEY_VAL(KEY_VAL), .N_TRAP(N_TRAP), .TRAP_EXP(TRAP_EXP)
) u_chk (
  .tck(tck), .rst_n(glob_rst_n), .seg_sel(seg_sel), .seg_si(seg_si),
  .seg_so(seg_so), .scan_out(scan_out), .lsib_sh(lsib_sh), .locked(locked),
  .key_uq(key_uq), .trap_uq(trap_uq)
);

// File: tb/lsib_net_tb.sv
`timescale 1ns/1ps
module lsib_net_tb;
  localparam int        KW  = 8;
  localparam int        NT  = 2;
  localparam int        DW  = 4;
  localparam int        SW  = 3;
  localparam logic [7:0] KEY = 8'hA5;

  logic tck = 1'b0;
  always #2 tck = ~tck;

  logic glob_rst_n = 1'b0;
  logic cap_en = 1'b0, shf_en = 1'b0, upd_en = 1'b0, scan_in = 1'b0;
  logic scan_out, seg_sel, seg_si, seg_so;

  // Stand-in hidden segment: SW bits, shifting only while selected.
  logic [SW-1:0] seg_reg = '0;
  always @(posedge tck) if (shf_en && seg_sel) seg_reg <= {seg_reg[SW-2:0], seg_si};
  assign seg_so = seg_reg[SW-1];

  lsib_net #(.KEY_W(KW), .KEY_VAL(KEY), .N_TRAP(NT), .TRAP_EXP('0), .DECOY_W(DW)) u_dut (
    .tck(tck), .glob_rst_n(glob_rst_n), .cap_en(cap_en), .shf_en(shf_en),
    .upd_en(upd_en), .scan_in(scan_in), .scan_out(scan_out),
    .seg_sel(seg_sel), .seg_si(seg_si), .seg_so(seg_so)
  );

  int errs = 0, checks = 0;
  bit done = 0;
  bit m_lsib, m_dsib, m_lock;
  bit [7:0] m_key;
  bit [1:0] m_trap;
  bit [3:0] m_dec;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit c, input bit s, input bit u, input bit d, output bit q);
    @(posedge tck); #1;
    cap_en = c; shf_en = s; upd_en = u; scan_in = d;
    #2; q = scan_out;
  endtask

  // Path image, index 0 nearest scan_out, shaped by the current model state.
  function automatic void build(input bit lw, input bit dw, input bit [1:0] tr,
                                input bit [7:0] key, input bit [3:0] dec,
                                output logic [31:0] v, output logic [31:0] m, output int len);
    int p = 0;
    v = '0; m = '0;
    if (m_lsib) p += SW;
    v[p] = lw; m[p] = 1'b1; p++;
    if (m_dsib) for (int i = DW-1; i >= 0; i--) begin v[p] = dec[i]; m[p] = 1'b1; p++; end
    v[p] = dw; m[p] = 1'b1; p++;
    v[p] = tr[1]; m[p] = 1'b1; p++;
    v[p] = tr[0]; m[p] = 1'b1; p++;
    for (int k = KW-1; k >= 0; k--) begin v[p] = key[k]; m[p] = 1'b1; p++; end
    len = p;
  endfunction

  task automatic scan(input logic [31:0] v, input int len, output logic [31:0] r);
    bit q;
    r = '0;
    cyc(1, 0, 0, 0, q);
    for (int i = 0; i < len; i++) begin cyc(0, 1, 0, v[i], q); r[i] = q; end
    cyc(0, 0, 1, 0, q);
    cyc(0, 0, 0, 0, q);
  endtask

  function automatic bit may_open(input bit [7:0] key, input bit [1:0] tr);
    return key == KEY && tr == 2'b00 && !m_lock;
  endfunction

  task automatic access(input bit lw, input bit dw, input bit [1:0] tr,
                        input bit [7:0] key, input bit [3:0] dec, input string req);
    logic [31:0] v, m, e, m2, r;
    int len, len2;
    bit ok;
    build(lw, dw, tr, key, dec, v, m, len);
    build(m_lsib, m_dsib, m_trap, m_key, m_dec, e, m2, len2);
    scan(v, len, r);
    chk("R7 readback", int'(r & m), int'(e & m));
    ok = may_open(key, tr);
    if (tr != 2'b00) m_lock = 1;
    if (m_dsib) m_dec = dec;
    m_lsib = lw && ok;
    m_dsib = dw;
    m_key  = key;
    m_trap = tr;
    chk(req, seg_sel, m_lsib);
  endtask

  task automatic measure(output int n);
    bit q;
    n = 0;
    for (int i = 0; i < 40; i++) cyc(0, 1, 0, 0, q);
    cyc(0, 1, 0, 1, q);
    for (int k = 1; k <= 40; k++) begin
      cyc(0, 1, 0, 0, q);
      if (q && n == 0) n = k;
    end
    cyc(0, 0, 0, 0, q);
  endtask

  function automatic int exp_len();
    return KW + NT + 2 + (m_dsib ? DW : 0) + (m_lsib ? SW : 0);
  endfunction

  task automatic do_reset();
    @(posedge tck); #1;
    glob_rst_n = 1'b0; cap_en = 0; shf_en = 0; upd_en = 0;
    repeat (2) @(posedge tck);
    #1;
    chk("R1 seg_sel in reset", seg_sel, 0);
    glob_rst_n = 1'b1;
    m_lsib = 0; m_dsib = 0; m_lock = 0; m_key = '0; m_trap = '0; m_dec = '0;
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_up();
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    m_lsib = 0; m_dsib = 0; m_lock = 0; m_key = '0; m_trap = '0; m_dec = '0;
    do_reset();

    // R1: reset state and bare path length.
    chk("R1 seg_sel after reset", seg_sel, 0);
    measure(n); chk("R1 reset path length", n, KW + NT + 2);
    access(0, 0, 2'b00, 8'h00, 4'h0, "R1 closed idle");

    // R3 and R2: correct key opens, the segment is spliced in.
    access(1, 0, 2'b00, KEY, 4'h0, "R3 correct key opens");
    measure(n); chk("R2 open path length", n, KW + NT + 2 + SW);
    // R3: wrong key, one bit off, writing 1 leaves it closed.
    access(1, 0, 2'b00, KEY ^ 8'h10, 4'h0, "R3 wrong key stays closed");
    measure(n); chk("R2 closed path length", n, KW + NT + 2);
    // R9: writing 0 closes an open cell regardless of the key.
    access(1, 0, 2'b00, KEY, 4'h0, "R3 reopen");
    access(0, 0, 2'b00, 8'h3C, 4'h0, "R9 write 0 closes");

    // R6: decoy opens freely, holds data, never drives seg_sel.
    access(0, 1, 2'b00, 8'h00, 4'h0, "R6 decoy opens");
    measure(n); chk("R6 decoy path length", n, KW + NT + 2 + DW);
    access(0, 1, 2'b00, 8'h00, 4'hB, "R6 decoy write");
    access(0, 0, 2'b00, 8'h00, 4'h6, "R6 decoy readback then close");

    // R4: trap fired together with the right key.
    access(1, 0, 2'b01, KEY, 4'h0, "R4 trap blocks same update");
    access(1, 0, 2'b00, KEY, 4'h0, "R5 lock sticky");
    access(1, 0, 2'b00, KEY, 4'h0, "R5 lock sticky again");
    measure(n); chk("R8 locked path length", n, KW + NT + 2);

    // R5: only the global reset clears the lock.
    do_reset();
    measure(n); chk("R1 length after reset", n, KW + NT + 2);
    access(1, 0, 2'b00, KEY, 4'h0, "R5 opens after reset");
    access(0, 0, 2'b10, KEY, 4'h0, "R4 trap1 fires");
    access(1, 0, 2'b00, KEY, 4'h0, "R4 locked stays closed");

    // Constrained random mix.
    for (int it = 0; it < 80; it++) begin
      bit [7:0] key;
      bit [1:0] tr;
      key = ($urandom % 3 == 0) ? KEY : 8'($urandom);
      tr  = ($urandom % 10 == 0) ? 2'(1 + $urandom % 3) : 2'b00;
      access(($urandom % 4) != 0, 1'($urandom), tr, key, 4'($urandom), "R3 random access");
      if (it % 16 == 15) begin
        measure(n); chk("R8 random path length", n, exp_len());
      end
      if (m_lock && ($urandom % 3 == 0)) do_reset();
    end

    done = 1;
    finish_up();
  end
endmodule